// File: doc/BRIEF.md
# Cascaded Programmable UART Clock Divider

This block turns the CPU clock into a programmable serial baud clock. Five fixed divide stages sit in a chain: four binary stages dividing by 2, 4, 16 and 256, and one divide-by-3 stage. Each stage is switched in or out by its own bit of a configuration register. The output frequency is therefore the input frequency divided by 3^m · 2^n, where m is the divide-by-3 enable bit and n is the 4-bit value formed by the binary-stage enables. A stage that is switched out is bypassed by a multiplexer in the clock path; its clock is never gated.

The configuration register is reached through an 8-bit I/O port on a Z80-style bus. Software can write it and read it back. The same register also holds a watchdog-enable bit, which the block only stores and exports. Reset clears every stage counter and the register, so after reset the output clock equals the input clock.

Top module: `uart_clkdiv_cfg`

## Requirements
- R1: After reset the register reads back 0x00, `wdog_en` is 0, and `uart_clk` runs at the input clock rate.
- R2: A write is taken on the rising clock edge when `iorq_n`=0, `wr_n`=0, `m1_n`=1 and `io_addr` equals 0x6D. Bits 5..0 of `io_wdata` are then stored.
- R3: The register is left unchanged by a write with `m1_n`=0, by a write to any other address, and by a read.
- R4: While `iorq_n`=0, `rd_n`=0, `m1_n`=1 and `io_addr`=0x6D, `rd_oe` is 1 and `rd_data` carries the stored bits 5..0. At all other times `rd_oe` is 0 and `rd_data` is 0x00.
- R5: `wdog_en` equals stored bit 5 from the edge after the write that sets or clears it.
- R6: Once settled, the `uart_clk` period is 3^b4 · 2^(b0 + 2·b1 + 4·b2 + 8·b3) input periods for every one of the 32 codes in bits 4..0. Bit 0 selects /2, bit 1 /4, bit 2 /16, bit 3 /256 and bit 4 /3.
- R7: When bit 4 is 0, `uart_clk` has a 50% duty cycle.
- R8: When bit 4 is 1, `uart_clk` is high for exactly one third of its period, which is one period of the third stage's input.
- R9: Bits 7..6 always read back as 0, even after 1s have been written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock, source of the divided clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Low byte of the I/O address |
| io_wdata | input | 8 | Write data from the bus |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Machine-cycle-one, active low; low marks interrupt acknowledge |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rd_data | output | 8 | Register contents during a read of the port, else zero |
| rd_oe | output | 1 | High while this block drives read data |
| uart_clk | output | 1 | Divided UART clock |
| wdog_en | output | 1 | Stored watchdog-enable bit |

## Verification
A corrupted register bit shows at the ports within one cycle. It appears on the next read of the port as a wrong `rd_data` value, or on `wdog_en` directly. A stage counter that skips a count or fails to wrap does not appear at once: the error surfaces only as a wrong period or wrong high time in `uart_clk`. For the large divisors that can take thousands of input cycles. The bench therefore measures both the period and the high time of the settled output for every divisor code. It also compares the register view against a reference model on every clock.

// File: rtl/ucd_pkg.sv
`timescale 1ns/1ps
package ucd_pkg;
   localparam int N_BIN    = 4;   // number of binary divide stages
   localparam int CFG_W    = 6;   // implemented register bits
   localparam int TRI_BIT  = 4;   // enable of the odd-ratio stage
   localparam int WDOG_BIT = 5;   // stored watchdog enable
endpackage

// File: rtl/ucd_bin_stage.sv
`timescale 1ns/1ps
// Divide by 2**LOG2 with 50% duty: output is the counter MSB.
module ucd_bin_stage #(
   parameter int LOG2 = 1
) (
   input  logic clk_in,
   input  logic rst_n,
   output logic div_out
);
   if (LOG2 < 1 || LOG2 > 16) begin : g_bad_log2
      $error("ucd_bin_stage: LOG2 out of range");
   end

   logic [LOG2-1:0] cnt_q;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign div_out = cnt_q[LOG2-1];
endmodule

// File: rtl/ucd_mod_stage.sv
`timescale 1ns/1ps
// Divide by DIV; output high for one input period of every DIV.
module ucd_mod_stage #(
   parameter int DIV = 3
) (
   input  logic clk_in,
   input  logic rst_n,
   output logic div_out
);
   if (DIV < 2 || DIV > 16) begin : g_bad_div
      $error("ucd_mod_stage: DIV out of range");
   end

   localparam int CW = $clog2(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign div_out = (cnt_q == LAST);

   // counter never leaves 0..DIV-1, so the high phase is exactly one input period
   p_mod_range_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/ucd_div_chain.sv
`timescale 1ns/1ps
module ucd_div_chain import ucd_pkg::*; #(
   parameter int BIN0_LOG2 = 1,
   parameter int BIN1_LOG2 = 2,
   parameter int BIN2_LOG2 = 4,
   parameter int BIN3_LOG2 = 8,
   parameter int TRI_DIV   = 3
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic [N_BIN-1:0] bin_en,
   input  logic             tri_en,
   output logic             clk_out
);
   localparam int LOG2S [N_BIN] = '{BIN0_LOG2, BIN1_LOG2, BIN2_LOG2, BIN3_LOG2};

   logic tap [N_BIN+1];
   assign tap[0] = clk_in;

   for (genvar g = 0; g < N_BIN; g++) begin : g_bin
      logic st_out;
      ucd_bin_stage #(.LOG2(LOG2S[g])) u_stage (
         .clk_in (tap[g]),
         .rst_n  (rst_n),
         .div_out(st_out)
      );
      // bypass multiplexer: disabled stage passes its input straight on
      assign tap[g+1] = bin_en[g] ? st_out : tap[g];
   end

   logic tri_out;
   ucd_mod_stage #(.DIV(TRI_DIV)) u_tri (
      .clk_in (tap[N_BIN]),
      .rst_n  (rst_n),
      .div_out(tri_out)
   );

   assign clk_out = tri_en ? tri_out : tap[N_BIN];
endmodule

// File: rtl/ucd_cfg_port.sv
`timescale 1ns/1ps
module ucd_cfg_port import ucd_pkg::*; #(
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h6D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              iorq_n,
   input  logic              m1_n,
   input  logic              wr_n,
   input  logic              rd_n,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);
   if (DATA_W < CFG_W) begin : g_bad_width
      $error("ucd_cfg_port: data bus narrower than register");
   end

   logic sel, wr_hit;

   // m1_n low with iorq_n low is an interrupt acknowledge, not a port access
   assign sel    = !iorq_n && m1_n && (io_addr == PORT_ADDR);
   assign wr_hit = sel && !wr_n;
   assign rd_oe  = sel && !rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_hit) cfg_q <= io_wdata[CFG_W-1:0];
   end

   always_comb begin
      rd_data = '0;
      if (rd_oe) rd_data[CFG_W-1:0] = cfg_q;
   end

   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> cfg_q == $past(io_wdata[CFG_W-1:0]));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(cfg_q));
endmodule

// File: rtl/uart_clkdiv_cfg.sv
`timescale 1ns/1ps
module uart_clkdiv_cfg import ucd_pkg::*; #(
   parameter int               ADDR_W    = 8,
   parameter int               DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h6D,
   parameter int               BIN0_LOG2 = 1,
   parameter int               BIN1_LOG2 = 2,
   parameter int               BIN2_LOG2 = 4,
   parameter int               BIN3_LOG2 = 8,
   parameter int               TRI_DIV   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              iorq_n,
   input  logic              m1_n,
   input  logic              wr_n,
   input  logic              rd_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              uart_clk,
   output logic              wdog_en
);
   logic [CFG_W-1:0] cfg;

   ucd_cfg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .io_wdata(io_wdata),
      .iorq_n  (iorq_n),
      .m1_n    (m1_n),
      .wr_n    (wr_n),
      .rd_n    (rd_n),
      .cfg_q   (cfg),
      .rd_data (rd_data),
      .rd_oe   (rd_oe)
   );

   ucd_div_chain #(
      .BIN0_LOG2(BIN0_LOG2), .BIN1_LOG2(BIN1_LOG2),
      .BIN2_LOG2(BIN2_LOG2), .BIN3_LOG2(BIN3_LOG2), .TRI_DIV(TRI_DIV)
   ) u_chain (
      .clk_in (clk),
      .rst_n  (rst_n),
      .bin_en (cfg[N_BIN-1:0]),
      .tri_en (cfg[TRI_BIT]),
      .clk_out(uart_clk)
   );

   assign wdog_en = cfg[WDOG_BIT];

   p_wdog_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!iorq_n && m1_n && !wr_n && io_addr == PORT_ADDR)
      |=> wdog_en == $past(io_wdata[WDOG_BIT]));

   p_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((!iorq_n && m1_n && !wr_n && io_addr == PORT_ADDR)
       ##1 (!iorq_n && m1_n && !rd_n && io_addr == PORT_ADDR))
      |-> rd_oe && rd_data[CFG_W-1:0] == $past(io_wdata[CFG_W-1:0]));
endmodule

// File: tb/uart_clkdiv_cfg_tb.sv
`timescale 1ns/1ps
module uart_clkdiv_cfg_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n;
   logic [7:0] io_addr, io_wdata;
   logic       iorq_n, m1_n, wr_n, rd_n;
   logic [7:0] rd_data, rd_data_s;
   logic       rd_oe, rd_oe_s, uclk, uclk_s, wdog_en, wdog_en_s;

   uart_clkdiv_cfg u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .iorq_n(iorq_n), .m1_n(m1_n), .wr_n(wr_n), .rd_n(rd_n),
      .rd_data(rd_data), .rd_oe(rd_oe), .uart_clk(uclk), .wdog_en(wdog_en));

   // shortened largest stage so all 32 codes fit in the run time
   uart_clkdiv_cfg #(.BIN3_LOG2(4)) u_dut_short (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .iorq_n(iorq_n), .m1_n(m1_n), .wr_n(wr_n), .rd_n(rd_n),
      .rd_data(rd_data_s), .rd_oe(rd_oe_s), .uart_clk(uclk_s), .wdog_en(wdog_en_s));

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic use_short = 1'b0;
   wire  mclk = use_short ? uclk_s : uclk;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [5:0] m_cfg;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_cfg <= 6'd0;
      else if (!iorq_n && !wr_n && m1_n && io_addr == 8'h6D) m_cfg <= io_wdata[5:0];
   end

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit   exp_oe = !iorq_n && !rd_n && m1_n && io_addr == 8'h6D;
         automatic logic [7:0] exp_d = exp_oe ? {2'b00, m_cfg} : 8'h00;
         chk(wdog_en == m_cfg[5],   "R5", "wdog_en",       wdog_en,   m_cfg[5]);
         chk(wdog_en_s == m_cfg[5], "R5", "wdog_en short", wdog_en_s, m_cfg[5]);
         chk(rd_oe == exp_oe,       "R4", "rd_oe",         rd_oe,     exp_oe);
         chk(rd_data == exp_d,      "R4", "rd_data",       rd_data,   exp_d);
         chk(rd_data_s == exp_d,    "R4", "rd_data short", rd_data_s, exp_d);
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_idle();
      iorq_n = 1'b1; m1_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
      io_addr = 8'h00; io_wdata = 8'h00;
   endtask

   task automatic io_wr(input logic [7:0] a, input logic [7:0] d, input logic m1);
      @(posedge clk); #1;
      io_addr = a; io_wdata = d; iorq_n = 1'b0; wr_n = 1'b0; m1_n = m1;
      @(posedge clk); #1;
      bus_idle();
   endtask

   task automatic io_rd_chk(input logic [7:0] exp, input string req);
      @(posedge clk); #1;
      io_addr = 8'h6D; iorq_n = 1'b0; rd_n = 1'b0; m1_n = 1'b1;
      @(negedge clk);
      chk(rd_oe && rd_data == exp,     req, "readback",       rd_data,   exp);
      chk(rd_oe_s && rd_data_s == exp, req, "readback short", rd_data_s, exp);
      @(posedge clk); #1;
      bus_idle();
   endtask

   function automatic longint ratio(input logic [4:0] code, input int l3);
      int e = (code[0] ? 1 : 0) + (code[1] ? 2 : 0) + (code[2] ? 4 : 0) + (code[3] ? l3 : 0);
      return (code[4] ? 3 : 1) * (longint'(1) << e);
   endfunction

   // R6 period, R7 / R8 high time of the settled output
   task automatic measure(input logic [4:0] code, input bit short_inst);
      realtime t_r2, t_f, t_r3;
      longint  per, hi, exp_per, exp_hi;
      use_short = short_inst;
      io_wr(8'h6D, {3'b000, code}, 1'b1);
      @(posedge mclk);
      @(posedge mclk); t_r2 = $realtime;
      @(negedge mclk); t_f  = $realtime;
      @(posedge mclk); t_r3 = $realtime;
      per     = longint'((t_r3 - t_r2) * 1000.0);
      hi      = longint'((t_f - t_r2) * 1000.0);
      exp_per = ratio(code, short_inst ? 4 : 8) * 5000;
      exp_hi  = code[4] ? exp_per / 3 : exp_per / 2;
      chk(per == exp_per, "R6", $sformatf("period code=%0d short=%0d", code, short_inst), per, exp_per);
      if (code[4]) chk(hi == exp_hi, "R8", $sformatf("high code=%0d", code), hi, exp_hi);
      else         chk(hi == exp_hi, "R7", $sformatf("high code=%0d", code), hi, exp_hi);
   endtask

   initial begin
      bus_idle();
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk(wdog_en == 1'b0, "R1", "wdog_en after reset", wdog_en, 0);
      io_rd_chk(8'h00, "R1");
      measure(5'd0, 1'b0);   // R1: output equals input clock

      // R2 / R9: write with upper bits set, they read back zero; R5 wdog set
      io_wr(8'h6D, 8'hFF, 1'b1);
      @(negedge clk);
      chk(wdog_en == 1'b1, "R5", "wdog_en after set", wdog_en, 1);
      io_rd_chk(8'h3F, "R9");
      io_wr(8'h6D, 8'h15, 1'b1);
      io_rd_chk(8'h15, "R2");

      // R3: ignored accesses
      io_wr(8'h6D, 8'h2A, 1'b0);   // interrupt acknowledge cycle
      io_rd_chk(8'h15, "R3");
      io_wr(8'h6C, 8'h2A, 1'b1);   // neighbour address
      io_rd_chk(8'h15, "R3");
      io_wr(8'hED, 8'h2A, 1'b1);   // differs in top bit
      io_rd_chk(8'h15, "R3");
      io_rd_chk(8'h15, "R3");       // read leaves it unchanged
      io_wr(8'h6D, 8'h20, 1'b1);
      @(negedge clk);
      chk(wdog_en == 1'b1, "R5", "wdog_en bit5 only", wdog_en, 1);
      io_rd_chk(8'h20, "R2");

      // R6 / R7 / R8: every code on the shortened instance
      for (int c = 0; c < 32; c++) measure(5'(c), 1'b1);
      // default stage sizes, codes using the largest stage
      measure(5'h08, 1'b0);
      measure(5'h18, 1'b0);
      measure(5'h0B, 1'b0);
      measure(5'h13, 1'b0);

      // R1: reset mid-run clears register
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      io_rd_chk(8'h00, "R1");
      measure(5'd0, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule